// File: doc/BRIEF.md
# Radio Controller SPI Access Port

This block is the serial front end that a host microcontroller uses to reach the control side of a low-power radio transceiver. The host is a 4-wire SPI master using mode 0: the clock idles low, MOSI is sampled on the rising edge, and bytes travel MSB first. The block samples SCLK, chip-select and MOSI with the core clock through synchronizers. It decodes the first byte of every access and turns the bytes that follow into register-file updates, command pulses, FIFO pushes and pops, or RAM cycles.

Pulling chip-select low starts a frame. While the host shifts in the header byte, the block shifts out the current radio status byte. Bit 7 of the header picks register space (0) or RAM space (1).

In register space, bit 6 is the read flag and bits 5:0 are the address. The address either names a configuration register, fires a command strobe, or opens one of the two FIFO ports. When a register or strobe access completes, the next byte inside the same frame is a new header.

A RAM access takes a second header byte that carries the bank and a read-only flag. The RAM access is then refused if the crystal has not been reported stable. Raising chip-select at any point abandons whatever is in progress.

Top module: `radio_spi_access`

## Requirements
- R1: After reset, MISO, every strobe line, the FIFO push and pop lines and the RAM write enable are low, and all 33 configuration registers read as zero.
- R2: Every header byte, including each further header chained inside one frame, returns on MISO the value of `status_i` captured when that header starts.
- R3: A header with bit 7 = 0, bit 6 = 0 and address 0x10 to 0x30, followed by two bytes (high byte first), loads register index (address − 0x10) with that 16-bit value. Registers change on no other input.
- R4: A header with bit 7 = 0, bit 6 = 1 and a register address returns the register's high byte and then its low byte during the next two bytes.
- R5: Register-space addresses 0x0F and 0x31 to 0x3D behave as two-byte register accesses that change no register, and reads of them return 0x00 bytes.
- R6: Addresses 0x01 to 0x0E drive strobe bit (address) high for exactly one core clock at the end of the header, and address 0x00 is a no-op that pulses nothing. A strobe takes no data bytes, and the byte after it is a new header.
- R7: After header address 0x3E, every complete following byte of the frame is pushed to the transmit FIFO, in order.
- R8: After header address 0x3F, each following byte returns the receive FIFO head on MISO and pops it once that byte completes.
- R9: A header with bit 7 = 1 gives a 7-bit RAM address in bits 6:0. The second byte gives the bank in bits 7:6 and a read-only flag in bit 5. Each later byte returns RAM[{bank, address}], and the address then increments, wrapping within the bank.
- R10: With read-only = 0, each data byte is written to the current RAM address before that address increments. With read-only = 1, no RAM write occurs.
- R11: If `xtal_stable_i` is low when the bank byte completes, the rest of the frame writes no RAM and returns 0x00.
- R12: Raising chip-select mid-byte or mid-access discards the partial access, including a register write that has received only its high byte. The next frame starts with a fresh header and status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock from host |
| cs_n_i | input | 1 | SPI chip-select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host, low while deselected |
| status_i | input | 8 | Radio status byte returned with each header |
| xtal_stable_i | input | 1 | Crystal oscillator stable; gates RAM access |
| strobe_o | output | 15 | One-clock command pulses, bit index = address |
| txf_push_o | output | 1 | Transmit FIFO push |
| txf_data_o | output | 8 | Transmit FIFO write byte |
| rxf_pop_o | output | 1 | Receive FIFO pop |
| rxf_data_i | input | 8 | Receive FIFO head (show-ahead) |
| ram_addr_o | output | 9 | RAM address {bank, offset} |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_rdata_i | input | 8 | RAM read byte, combinational from ram_addr_o |
| cfg_o | output | 528 | Flattened configuration registers, index 0 in bits 15:0 |

## Verification
The bench targets the edges of the address map: 0x0F and 0x31 sit next to the register window, 0x00 is the no-op strobe, and a decoder that is off by one there would corrupt a register or fire a wrong strobe. It chains strobe and register headers inside one frame, so a design that loses its byte phase after a strobe would read data as a header and return the wrong status. RAM bursts that start at offset 0x7E test wrap-around within the bank, since a design that carries into the bank bits would touch another bank. It also covers the read-only flag, the crystal gate and frames cut off after a lone high byte or after three bits; these would show up as RAM writes where none are allowed, or as a register that takes a half-written value or a stale bit count.

// File: rtl/rsa_pkg.sv
// Shared types for the radio SPI access port.
// Assumes: one transaction state machine per instance.
package rsa_pkg;
    localparam int RAM_OFS_W  = 7;
    localparam int RAM_BANK_W = 2;
    localparam int RAM_ADDR_W = RAM_OFS_W + RAM_BANK_W;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_REG_HI,
        ST_REG_LO,
        ST_TXF,
        ST_RXF,
        ST_RAM_BANK,
        ST_RAM_DATA,
        ST_SINK
    } xfer_state_t;
endpackage

// File: rtl/rsa_serdes.sv
// SPI mode 0 byte serializer/deserializer running on the core clock.
// Synchronizes SCLK, CS_N and MOSI, samples MOSI on rising SCLK and shifts MISO
// on falling SCLK. Each received byte yields a one-clock valid pulse.
// Assumes: SCLK is slower than clk/8 so that synchronized edges stay separate.
module rsa_serdes #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic       load_i,
    input  logic [7:0] load_byte_i,
    output logic       miso_o,
    output logic       cs_active_o,
    output logic       cs_start_o,
    output logic       byte_vld_o,
    output logic [7:0] rx_byte_o
);
    logic [SYNC_STAGES:0]   sclk_s;
    logic [SYNC_STAGES:0]   cs_s;
    logic [SYNC_STAGES-1:0] mosi_s;
    logic [2:0]             bit_cnt;
    logic [6:0]             rx_sh;
    logic [7:0]             tx_sh;
    logic                   sclk_rise;
    logic                   sclk_fall;
    logic                   mosi_bit;

    // Synchronizer chains, with one extra stage on SCLK and CS_N for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[SYNC_STAGES-1:0], sclk_i};
            cs_s   <= {cs_s[SYNC_STAGES-1:0], cs_n_i};
            mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi_i};
        end
    end

    assign sclk_rise   = sclk_s[SYNC_STAGES-1] & ~sclk_s[SYNC_STAGES];
    assign sclk_fall   = ~sclk_s[SYNC_STAGES-1] & sclk_s[SYNC_STAGES];
    assign cs_active_o = ~cs_s[SYNC_STAGES-1];
    assign cs_start_o  = ~cs_s[SYNC_STAGES-1] & cs_s[SYNC_STAGES];
    assign mosi_bit    = mosi_s[SYNC_STAGES-1];

    // Receive side: collect bits on rising SCLK and flag each complete byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            rx_byte_o  <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (!cs_active_o) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                if (bit_cnt == 3'd7) begin
                    rx_byte_o  <= {rx_sh, mosi_bit};
                    byte_vld_o <= 1'b1;
                    bit_cnt    <= '0;
                end else begin
                    rx_sh   <= {rx_sh[5:0], mosi_bit};
                    bit_cnt <= bit_cnt + 3'd1;
                end
            end
        end
    end

    // Transmit side: load a byte between bytes, shift on falling SCLK inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load_i) begin
            tx_sh <= load_byte_i;
        end else if (sclk_fall && cs_active_o && bit_cnt != 3'd0) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign miso_o = cs_active_o & tx_sh[7];

    p_byte_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(cs_active_o));
    p_frame_start_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start_o |-> (bit_cnt == 3'd0));
endmodule

// File: rtl/rsa_regbank.sv
// Configuration and status register bank, 16 bits per entry.
// Written one entry at a time; read through an index mux and exposed flattened.
// Assumes: an index at or beyond COUNT reads zero and is never written.
module rsa_regbank #(
    parameter int COUNT = 33,
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(COUNT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [WIDTH-1:0]       wdata_i,
    output logic [WIDTH-1:0]       rdata_o,
    output logic [COUNT*WIDTH-1:0] flat_o
);
    logic [WIDTH-1:0] regs [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_reg
        // One storage word: cleared by reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we_i && idx_i == IDX_W'(g)) begin
                regs[g] <= wdata_i;
            end
        end
        assign flat_o[g*WIDTH +: WIDTH] = regs[g];
    end

    // Read mux with zero for out-of-range indices.
    always_comb begin
        rdata_o = '0;
        if (int'(idx_i) < COUNT) begin
            rdata_o = regs[idx_i];
        end
    end

    p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(flat_o));
endmodule

// File: rtl/rsa_ctrl.sv
// Transaction decoder: turns the received byte stream into register, strobe,
// FIFO and RAM operations and picks the next byte to return on MISO.
// Assumes: byte_vld_i pulses once per byte; loads happen one clock later, well
// before the next falling SCLK edge.
module rsa_ctrl
    import rsa_pkg::*;
#(
    parameter int REG_BASE = 16,
    parameter int REG_COUNT = 33,
    parameter int REG_IW = 6,
    parameter int STROBE_N = 15,
    parameter logic [5:0] TXF_ADDR = 6'h3E,
    parameter logic [5:0] RXF_ADDR = 6'h3F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_active_i,
    input  logic                  cs_start_i,
    input  logic                  byte_vld_i,
    input  logic [7:0]            rx_byte_i,
    input  logic [7:0]            status_i,
    input  logic                  xtal_i,
    output logic                  load_o,
    output logic [7:0]            load_byte_o,
    output logic [STROBE_N-1:0]   strobe_o,
    output logic                  txf_push_o,
    output logic [7:0]            txf_data_o,
    output logic                  rxf_pop_o,
    input  logic [7:0]            rxf_data_i,
    output logic [RAM_ADDR_W-1:0] ram_addr_o,
    output logic                  ram_we_o,
    output logic [7:0]            ram_wdata_o,
    input  logic [7:0]            ram_rdata_i,
    output logic                  reg_we_o,
    output logic [REG_IW-1:0]     reg_idx_o,
    output logic [15:0]           reg_wdata_o,
    input  logic [15:0]           reg_rdata_i
);
    xfer_state_t           state;
    logic                  rd_q;
    logic                  reg_ok_q;
    logic [5:0]            addr_q;
    logic [7:0]            hi_q;
    logic [RAM_OFS_W-1:0]  ram_ofs_q;
    logic [RAM_BANK_W-1:0] bank_q;
    logic                  ro_q;
    logic                  load_pend_q;
    logic                  hdr_cmd;
    logic [5:0]            hdr_addr;
    logic                  hdr_is_strobe;
    logic                  hdr_in_regs;
    logic [5:0]            rel_addr;

    assign hdr_addr      = rx_byte_i[5:0];
    assign hdr_cmd       = byte_vld_i & (state == ST_HDR) & ~rx_byte_i[7];
    assign hdr_is_strobe = ({1'b0, hdr_addr} < 7'(STROBE_N));
    assign hdr_in_regs   = ({1'b0, hdr_addr} >= 7'(REG_BASE)) &&
                           ({1'b0, hdr_addr} < 7'(REG_BASE + REG_COUNT));

    // Transaction state: advance once per byte, fall back to header on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_HDR;
            rd_q        <= 1'b0;
            reg_ok_q    <= 1'b0;
            addr_q      <= '0;
            hi_q        <= '0;
            ram_ofs_q   <= '0;
            bank_q      <= '0;
            ro_q        <= 1'b1;
            load_pend_q <= 1'b0;
        end else begin
            load_pend_q <= byte_vld_i | cs_start_i;
            if (!cs_active_i) begin
                state <= ST_HDR;
            end else if (byte_vld_i) begin
                unique case (state)
                    ST_HDR: begin
                        if (rx_byte_i[7]) begin
                            ram_ofs_q <= rx_byte_i[RAM_OFS_W-1:0];
                            state     <= ST_RAM_BANK;
                        end else begin
                            addr_q <= hdr_addr;
                            rd_q   <= rx_byte_i[6];
                            if (hdr_addr == TXF_ADDR) begin
                                state <= ST_TXF;
                            end else if (hdr_addr == RXF_ADDR) begin
                                state <= ST_RXF;
                            end else if (hdr_is_strobe) begin
                                state <= ST_HDR;
                            end else begin
                                reg_ok_q <= hdr_in_regs;
                                state    <= ST_REG_HI;
                            end
                        end
                    end
                    ST_REG_HI: begin
                        hi_q  <= rx_byte_i;
                        state <= ST_REG_LO;
                    end
                    ST_REG_LO: state <= ST_HDR;
                    ST_RAM_BANK: begin
                        bank_q <= rx_byte_i[7:6];
                        ro_q   <= rx_byte_i[5];
                        state  <= xtal_i ? ST_RAM_DATA : ST_SINK;
                    end
                    ST_RAM_DATA: ram_ofs_q <= ram_ofs_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Byte to return next: status for a header, otherwise data of the open access.
    always_comb begin
        load_byte_o = 8'h00;
        unique case (state)
            ST_HDR:      load_byte_o = status_i;
            ST_REG_HI:   load_byte_o = (rd_q && reg_ok_q) ? reg_rdata_i[15:8] : 8'h00;
            ST_REG_LO:   load_byte_o = (rd_q && reg_ok_q) ? reg_rdata_i[7:0] : 8'h00;
            ST_RXF:      load_byte_o = rxf_data_i;
            ST_RAM_DATA: load_byte_o = ram_rdata_i;
            default:     load_byte_o = 8'h00;
        endcase
    end

    assign load_o = load_pend_q & cs_active_i;

    // Strobe decode: address 0 is the status-only no-op.
    for (genvar g = 0; g < STROBE_N; g++) begin : g_stb
        if (g == 0) begin : g_nop
            assign strobe_o[g] = 1'b0;
        end else begin : g_fire
            assign strobe_o[g] = hdr_cmd & (hdr_addr == 6'(g));
        end
    end

    assign txf_push_o  = byte_vld_i & (state == ST_TXF);
    assign txf_data_o  = rx_byte_i;
    assign rxf_pop_o   = byte_vld_i & (state == ST_RXF);

    assign ram_addr_o  = {bank_q, ram_ofs_q};
    assign ram_we_o    = byte_vld_i & (state == ST_RAM_DATA) & ~ro_q;
    assign ram_wdata_o = rx_byte_i;

    assign rel_addr    = addr_q - 6'(REG_BASE);
    assign reg_idx_o   = rel_addr[REG_IW-1:0];
    assign reg_we_o    = byte_vld_i & (state == ST_REG_LO) & ~rd_q & reg_ok_q;
    assign reg_wdata_o = {hi_q, rx_byte_i};

    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));
    p_pop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop_o |=> !rxf_pop_o);
    p_refuse_ram_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAM_BANK && byte_vld_i && !xtal_i) |=> (state != ST_RAM_DATA));
    p_abort_to_header_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active_i |=> (state == ST_HDR));
    p_push_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txf_push_o |-> cs_active_i);
endmodule

// File: rtl/radio_spi_access.sv
// Top of the radio SPI access port: serializer, transaction decoder and the
// configuration register bank.
// Assumes: the receive FIFO and RAM behind the ports present read data
// combinationally and act on push/pop/write at the rising clk edge.
module radio_spi_access
    import rsa_pkg::*;
#(
    parameter int REG_BASE    = 16,
    parameter int REG_COUNT   = 33,
    parameter int STROBE_N    = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_i,
    input  logic                    cs_n_i,
    input  logic                    mosi_i,
    output logic                    miso_o,
    input  logic [7:0]              status_i,
    input  logic                    xtal_stable_i,
    output logic [STROBE_N-1:0]     strobe_o,
    output logic                    txf_push_o,
    output logic [7:0]              txf_data_o,
    output logic                    rxf_pop_o,
    input  logic [7:0]              rxf_data_i,
    output logic [RAM_ADDR_W-1:0]   ram_addr_o,
    output logic                    ram_we_o,
    output logic [7:0]              ram_wdata_o,
    input  logic [7:0]              ram_rdata_i,
    output logic [REG_COUNT*16-1:0] cfg_o
);
    localparam int REG_IW = $clog2(REG_COUNT);

    logic              load;
    logic [7:0]        load_byte;
    logic              cs_active;
    logic              cs_start;
    logic              byte_vld;
    logic [7:0]        rx_byte;
    logic              reg_we;
    logic [REG_IW-1:0] reg_idx;
    logic [15:0]       reg_wdata;
    logic [15:0]       reg_rdata;

    rsa_serdes #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_serdes (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .cs_n_i     (cs_n_i),
        .mosi_i     (mosi_i),
        .load_i     (load),
        .load_byte_i(load_byte),
        .miso_o     (miso_o),
        .cs_active_o(cs_active),
        .cs_start_o (cs_start),
        .byte_vld_o (byte_vld),
        .rx_byte_o  (rx_byte)
    );

    rsa_ctrl #(
        .REG_BASE (REG_BASE),
        .REG_COUNT(REG_COUNT),
        .REG_IW   (REG_IW),
        .STROBE_N (STROBE_N)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active_i(cs_active),
        .cs_start_i (cs_start),
        .byte_vld_i (byte_vld),
        .rx_byte_i  (rx_byte),
        .status_i   (status_i),
        .xtal_i     (xtal_stable_i),
        .load_o     (load),
        .load_byte_o(load_byte),
        .strobe_o   (strobe_o),
        .txf_push_o (txf_push_o),
        .txf_data_o (txf_data_o),
        .rxf_pop_o  (rxf_pop_o),
        .rxf_data_i (rxf_data_i),
        .ram_addr_o (ram_addr_o),
        .ram_we_o   (ram_we_o),
        .ram_wdata_o(ram_wdata_o),
        .ram_rdata_i(ram_rdata_i),
        .reg_we_o   (reg_we),
        .reg_idx_o  (reg_idx),
        .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata)
    );

    rsa_regbank #(
        .COUNT(REG_COUNT),
        .WIDTH(16),
        .IDX_W(REG_IW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (reg_we),
        .idx_i  (reg_idx),
        .wdata_i(reg_wdata),
        .rdata_o(reg_rdata),
        .flat_o (cfg_o)
    );
endmodule

// File: tb/radio_spi_access_tb.sv
// Self-checking bench: SPI master tasks, bench-side models of registers,
// FIFOs and RAM, random register traffic plus directed corner cases.
module radio_spi_access_tb;
    localparam int HALF = 8;
    localparam int NREG = 33;
    localparam int NSTB = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic          miso;
    logic [7:0]    st = 8'h00;
    logic          xtal = 1'b1;
    logic [NSTB-1:0] strobe;
    logic          txf_push, rxf_pop, ram_we;
    logic [7:0]    txf_data, rxf_data, ram_wdata, ram_rdata;
    logic [8:0]    ram_addr;
    logic [NREG*16-1:0] cfg;

    radio_spi_access u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso), .status_i(st), .xtal_stable_i(xtal), .strobe_o(strobe),
        .txf_push_o(txf_push), .txf_data_o(txf_data), .rxf_pop_o(rxf_pop),
        .rxf_data_i(rxf_data), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .cfg_o(cfg)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] model [NREG];
    logic [7:0]  ram [512];
    logic [7:0]  exp_ram [512];
    logic [7:0]  rxmem [64];
    logic [7:0]  txlog [64];
    int rx_idx = 0;
    int txn = 0;
    int stb_cnt [NSTB];

    // Peripheral models driven only by the DUT's port activity.
    assign rxf_data  = rxmem[rx_idx % 64];
    assign ram_rdata = ram[ram_addr];
    always @(posedge clk) begin
        if (rxf_pop) rx_idx <= rx_idx + 1;
        if (txf_push) begin txlog[txn % 64] <= txf_data; txn <= txn + 1; end
        if (ram_we) ram[ram_addr] <= ram_wdata;
        for (int i = 0; i < NSTB; i++) if (strobe[i]) stb_cnt[i] <= stb_cnt[i] + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_reg(input int addr);
        if (addr >= 16 && addr < 16 + NREG) return model[addr - 16];
        return 16'h0000;
    endfunction

    function automatic int ram_ix(input int bank, input int ofs);
        return bank * 128 + (ofs % 128);
    endfunction

    function automatic int stb_sum();
        int s = 0;
        for (int i = 0; i < NSTB; i++) s += stb_cnt[i];
        return s;
    endfunction

    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic sel();
        st = 8'($urandom);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic reg_write(input int addr, input logic [15:0] val);
        logic [7:0] r;
        sel();
        xfer({2'b00, 6'(addr)}, r); chk("R2 status on write header", r, st);
        xfer(val[15:8], r);
        xfer(val[7:0], r);
        desel();
        if (addr >= 16 && addr < 16 + NREG) model[addr - 16] = val;
    endtask

    task automatic reg_read(input int addr);
        logic [7:0] r, hi, lo;
        sel();
        xfer({2'b01, 6'(addr)}, r); chk("R2 status on read header", r, st);
        xfer(8'h00, hi);
        xfer(8'h00, lo);
        desel();
        chk((addr >= 16 && addr < 16 + NREG) ? "R4 register read" : "R5 unmapped read zero",
            {hi, lo}, exp_reg(addr));
    endtask

    task automatic check_cfg(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, cfg[i*16 +: 16], model[i]);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, b;
        logic [7:0] sent [8];
        int t0, s0, p0, a, k, base;
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
        for (int i = 0; i < NSTB; i++) stb_cnt[i] = 0;
        for (int i = 0; i < 64; i++) begin rxmem[i] = 8'($urandom); txlog[i] = 8'h00; end
        for (int i = 0; i < 512; i++) begin ram[i] = 8'($urandom); exp_ram[i] = ram[i]; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 miso idle", miso, 1'b0);
        chk("R1 strobes idle", strobe, '0);
        chk("R1 push/pop/we idle", {txf_push, rxf_pop, ram_we}, 3'b000);
        chk("R1 registers clear", (cfg == '0), 1'b1);

        // R3/R5: random register writes over the window and its neighbours
        for (int n = 0; n < 40; n++) begin
            a = 15 + ($urandom % 35);
            reg_write(a, 16'($urandom));
        end
        reg_write(16, 16'hA55A);
        reg_write(48, 16'h1234);
        reg_write(15, 16'hFFFF);
        reg_write(49, 16'hFFFF);
        reg_write(61, 16'hFFFF);
        check_cfg("R3 register contents");

        // R4/R5: random reads plus edges
        for (int n = 0; n < 25; n++) reg_read(15 + ($urandom % 35));
        reg_read(16); reg_read(48); reg_read(15); reg_read(49);

        // R6: each strobe address, one pulse on the matching line only
        for (int s = 0; s < NSTB; s++) begin
            s0 = stb_sum();
            p0 = stb_cnt[s];
            sel(); xfer({2'b00, 6'(s)}, r); desel();
            chk("R6 strobe status", r, st);
            chk("R6 strobe total pulses", stb_sum() - s0, (s == 0) ? 0 : 1);
            chk("R6 strobe line", stb_cnt[s] - p0, (s == 0) ? 0 : 1);
        end

        // R6/R2: strobes chained with a register read in one frame
        s0 = stb_sum();
        sel();
        xfer(8'h05, r); chk("R2 chained status 1", r, st);
        xfer(8'h47, r); chk("R2 chained status 2", r, st);
        xfer(8'h50, r); chk("R2 chained status 3", r, st);
        xfer(8'h00, r); b = r;
        xfer(8'h00, r);
        desel();
        chk("R6 chained pulses", stb_sum() - s0, 2);
        chk("R6 next byte is header", {b, r}, model[0]);

        // R7: transmit FIFO stream
        t0 = txn;
        sel(); xfer(8'h3E, r); chk("R2 txf status", r, st);
        for (int i = 0; i < 6; i++) begin sent[i] = 8'($urandom); xfer(sent[i], r); end
        desel();
        chk("R7 push count", txn - t0, 6);
        for (int i = 0; i < 6; i++) chk("R7 push data", txlog[(t0 + i) % 64], sent[i]);

        // R8: receive FIFO stream
        p0 = rx_idx;
        sel(); xfer(8'h7F, r); chk("R2 rxf status", r, st);
        for (int i = 0; i < 5; i++) begin xfer(8'hFF, r); chk("R8 rx byte", r, rxmem[(p0 + i) % 64]); end
        desel();
        chk("R8 pop count", rx_idx - p0, 5);

        // R9/R10: read-only burst across offset wrap in bank 2
        xtal = 1'b1;
        sel();
        xfer({1'b1, 7'h7E}, r); chk("R2 ram status", r, st);
        xfer({2'd2, 1'b1, 5'd0}, r);
        for (int i = 0; i < 4; i++) begin
            xfer(8'($urandom), r);
            chk("R9 ram read wrap", r, exp_ram[ram_ix(2, 126 + i)]);
        end
        desel();
        for (int i = 0; i < 512; i++) if (ram[i] !== exp_ram[i]) begin chk("R10 read-only no write", i, -1); break; end

        // R10: read-write burst in bank 1, returns old data, writes new
        base = 5;
        sel();
        xfer({1'b1, 7'(base)}, r);
        xfer({2'd1, 1'b0, 5'd0}, r);
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom);
            xfer(b, r);
            chk("R10 rw returns old", r, exp_ram[ram_ix(1, base + i)]);
            exp_ram[ram_ix(1, base + i)] = b;
        end
        desel();
        k = 0;
        for (int i = 0; i < 512; i++) if (ram[i] !== exp_ram[i]) k++;
        chk("R10 ram after rw burst", k, 0);

        // R11: crystal not stable refuses access
        xtal = 1'b0;
        sel();
        xfer({1'b1, 7'h10}, r);
        xfer({2'd3, 1'b0, 5'd0}, r);
        for (int i = 0; i < 3; i++) begin xfer(8'hA5, r); chk("R11 refused reads zero", r, 8'h00); end
        desel();
        xtal = 1'b1;
        k = 0;
        for (int i = 0; i < 512; i++) if (ram[i] !== exp_ram[i]) k++;
        chk("R11 refused no write", k, 0);

        // R12: abort after high byte, then after three bits
        sel();
        xfer(8'h13, r);
        xfer(8'hDE, r);
        desel();
        chk("R12 half write discarded", cfg[3*16 +: 16], model[3]);
        sel(); xfer_bits(8'hFF, 3, r); desel();
        reg_read(19);
        reg_write(19, 16'hBEEF);
        chk("R12 write after abort", cfg[3*16 +: 16], 16'hBEEF);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule